// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one PWM command into two gate enables for the upper and lower switches of a synchronous buck power stage. It does not insert a fixed dead time. Each gate is switched on only after the opposite gate has been sensed as discharged. The sensing uses three comparator flags that have already been digitized: lower-gate voltage high, switch-node voltage high, and upper gate-source voltage high. A flag reading 1 means the voltage is above its threshold; 0 means discharged or low. Every flag passes through a two-flop synchronizer before the sequencer uses it. The turn-off delay of each edge and the turn-on dwell after sensing are parameters counted in clock cycles.

There are two ways to turn on the lower gate. The primary path waits for the switch node to fall. A secondary path waits for the upper gate-source voltage to collapse and uses a longer dwell, so the bootstrap capacitor still recharges when the stage sinks current and the switch node stays high. An active-high run input acts as the active-low disable: while it is low both gates are off.

The states, with their `state_o` codes, are IDLE (0), HS_ON (1), HS_OFF (2, upper gate still driven during its turn-off delay), WAIT_SW (3, both off, waiting for discharge), LS_ON (4), LS_OFF (5, lower gate still driven during its turn-off delay) and WAIT_LG (6, both off, waiting for the lower gate). DISABLED is 7.

The transitions are:
- IDLE goes to WAIT_LG when PWM is 1 and to WAIT_SW when PWM is 0.
- LS_ON goes to LS_OFF when PWM rises.
- LS_OFF goes to WAIT_LG when its delay expires, or back to LS_ON if PWM returns low.
- WAIT_LG goes to HS_ON when its dwell completes, or to WAIT_SW if PWM falls.
- HS_ON goes to HS_OFF when PWM falls.
- HS_OFF goes to WAIT_SW when its delay expires, or back to HS_ON if PWM returns high.
- WAIT_SW goes to LS_ON when either dwell completes, or to WAIT_LG if PWM rises.
- Any state goes to DISABLED when run is low. DISABLED goes to IDLE when run is high.

Top module: `deadtime_gate_seq`

## Requirements
- R1: While reset is asserted, and right after it, both enables are 0 and `state_o` reads IDLE (0). On the first clock edge with run high, IDLE moves to WAIT_LG (6) if PWM is 1 and to WAIT_SW (3) if PWM is 0.
- R2: `state_o` always carries the code of the current state, using the encoding listed above.
- R3: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R4: On a clock edge that sees PWM high while in LS_ON, the state becomes LS_OFF. `ls_en_o` stays 1 for exactly LS_OFF_DLY edges, counting that one, and then drops as the state moves to WAIT_LG.
- R5: In WAIT_LG, `hs_en_o` rises only after the synchronized lower-gate flag has read 0 for HS_ON_DLY consecutive edges. The flag reaches the sequencer two edges after the pin changes. While the flag reads 1, the block keeps waiting indefinitely.
- R6: On a clock edge that sees PWM low while in HS_ON, the state becomes HS_OFF. `hs_en_o` stays 1 for exactly HS_OFF_DLY edges, counting that one, and then drops as the state moves to WAIT_SW.
- R7: In WAIT_SW, `ls_en_o` rises after the synchronized switch-node flag has read 0 for LS_ON_DLY consecutive edges. While both the switch-node flag and the upper gate-source flag read 1, it stays low.
- R8: In WAIT_SW, when the switch-node flag stays 1, `ls_en_o` rises once the synchronized upper gate-source flag has read 0 for LS_SEC_DLY consecutive edges. This dwell is always longer than LS_ON_DLY; it is forced to LS_ON_DLY+1 if set too short.
- R9: A PWM reversal cancels any pending sequence on the next edge. LS_OFF returns to LS_ON, HS_OFF returns to HS_ON, WAIT_LG moves to WAIT_SW, and WAIT_SW moves to WAIT_LG.
- R10: While run is low, both enables are 0 in the same cycle, and the next edge puts the state in DISABLED (7). The first edge with run high moves DISABLED to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, synchronous to clk; 1 requests the upper switch |
| run_i | input | 1 | Stage run; low disables switching and forces both enables to 0 |
| lsg_hi_i | input | 1 | Lower-gate comparator flag, 1 when that gate is above threshold (asynchronous) |
| sw_hi_i | input | 1 | Switch-node comparator flag, 1 when the node is above threshold (asynchronous) |
| hsg_hi_i | input | 1 | Upper gate-source comparator flag, 1 when above threshold (asynchronous) |
| hs_en_o | output | 1 | Upper switch gate enable |
| ls_en_o | output | 1 | Lower switch gate enable |
| state_o | output | 3 | Current sequencer state code |

## Verification
The assertions check several properties on every cycle:
- The two enables are mutually exclusive.
- A rising upper enable is always preceded by a low lower-gate flag and a high PWM.
- A rising lower enable is always preceded by a low switch-node or upper-gate flag and a low PWM.
- A low run input always lands in DISABLED.

Only the bench scenarios can show the exact dwell lengths:
- the turn-off hold times;
- that the secondary path is the slower one;
- the two-edge synchronizer latency;
- the cancellation of each pending edge on a PWM reversal.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HS_ON    = 3'd1,
        ST_HS_OFF   = 3'd2,
        ST_WAIT_SW  = 3'd3,
        ST_LS_ON    = 3'd4,
        ST_LS_OFF   = 3'd5,
        ST_WAIT_LG  = 3'd6,
        ST_DISABLED = 3'd7
    } seq_state_e;

    // index of each comparator flag inside the synchronized vector
    localparam int unsigned FLG_LG  = 0;
    localparam int unsigned FLG_SW  = 1;
    localparam int unsigned FLG_HG  = 2;
    localparam int unsigned FLG_NUM = 3;

    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

endpackage

// File: rtl/dtg_flag_sync.sv
module dtg_flag_sync #(
    parameter int unsigned N       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] chain_q [STAGES];

    // first stage samples the asynchronous comparator outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= RST_VAL;
        end else begin
            chain_q[0] <= async_i;
        end
    end

    // remaining stages resolve metastability
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[g] <= RST_VAL;
            end else begin
                chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dtg_dwell.sv
module dtg_dwell #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         hit_o
);

    logic [W-1:0] cnt_q;

    // counts consecutive cycles with run_i high; clr_i restarts it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the limit-th qualifying cycle completes the dwell
    assign hit_o = run_i && (cnt_q == (limit_i - 1'b1));

endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
    import dtg_pkg::*;
#(
    parameter int unsigned W          = 4,
    parameter int unsigned LS_OFF_DLY = 2,
    parameter int unsigned HS_ON_DLY  = 5,
    parameter int unsigned HS_OFF_DLY = 6,
    parameter int unsigned LS_ON_DLY  = 3,
    parameter int unsigned LS_SEC_DLY = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm_i,
    input  logic         run_i,
    input  logic         lg_s_i,
    input  logic         sw_s_i,
    input  logic         hg_s_i,
    input  logic         main_hit_i,
    input  logic         sec_hit_i,
    output logic         main_run_o,
    output logic         main_clr_o,
    output logic [W-1:0] main_limit_o,
    output logic         sec_run_o,
    output logic         sec_clr_o,
    output logic [W-1:0] sec_limit_o,
    output logic         hs_en_o,
    output logic         ls_en_o,
    output logic [2:0]   state_o
);

    seq_state_e st_q;
    seq_state_e st_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        if (!run_i) begin
            st_nx = ST_DISABLED;
        end else begin
            unique case (st_q)
                ST_DISABLED: st_nx = ST_IDLE;
                ST_IDLE:     st_nx = pwm_i ? ST_WAIT_LG : ST_WAIT_SW;
                ST_LS_ON:    if (pwm_i) st_nx = ST_LS_OFF;
                ST_LS_OFF: begin
                    if (!pwm_i)          st_nx = ST_LS_ON;
                    else if (main_hit_i) st_nx = ST_WAIT_LG;
                end
                ST_WAIT_LG: begin
                    if (!pwm_i)          st_nx = ST_WAIT_SW;
                    else if (main_hit_i) st_nx = ST_HS_ON;
                end
                ST_HS_ON:    if (!pwm_i) st_nx = ST_HS_OFF;
                ST_HS_OFF: begin
                    if (pwm_i)           st_nx = ST_HS_ON;
                    else if (main_hit_i) st_nx = ST_WAIT_SW;
                end
                ST_WAIT_SW: begin
                    if (pwm_i)                          st_nx = ST_WAIT_LG;
                    else if (main_hit_i || sec_hit_i)   st_nx = ST_LS_ON;
                end
                default: st_nx = ST_DISABLED;
            endcase
        end
    end

    // outputs: enables, timer control, status
    always_comb begin
        hs_en_o      = 1'b0;
        ls_en_o      = 1'b0;
        main_run_o   = 1'b0;
        main_limit_o = W'(1);
        sec_run_o    = 1'b0;
        sec_limit_o  = W'(LS_SEC_DLY);
        unique case (st_q)
            ST_HS_ON:  hs_en_o = run_i;
            ST_HS_OFF: begin
                hs_en_o      = run_i;
                main_run_o   = 1'b1;
                main_limit_o = W'(HS_OFF_DLY);
            end
            ST_LS_ON:  ls_en_o = run_i;
            ST_LS_OFF: begin
                ls_en_o      = run_i;
                main_run_o   = 1'b1;
                main_limit_o = W'(LS_OFF_DLY);
            end
            ST_WAIT_LG: begin
                main_run_o   = !lg_s_i;
                main_limit_o = W'(HS_ON_DLY);
            end
            ST_WAIT_SW: begin
                main_run_o   = !sw_s_i;
                main_limit_o = W'(LS_ON_DLY);
                sec_run_o    = !hg_s_i;
            end
            default: ;
        endcase
        main_clr_o = (st_nx != st_q) || !main_run_o;
        sec_clr_o  = (st_nx != st_q) || !sec_run_o;
        state_o    = st_q;
    end

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o)); // R3

    AST_HS_AFTER_LG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> ($past(!lg_s_i) && $past(pwm_i))); // R5

    AST_LS_AFTER_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en_o) |-> ($past(!sw_s_i || !hg_s_i) && $past(!pwm_i))); // R7

    AST_RUN_LOW_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_o == 3'd7)); // R10

endmodule

// File: rtl/deadtime_gate_seq.sv
module deadtime_gate_seq
    import dtg_pkg::*;
#(
    parameter int unsigned LS_OFF_DLY = 2,
    parameter int unsigned HS_ON_DLY  = 5,
    parameter int unsigned HS_OFF_DLY = 6,
    parameter int unsigned LS_ON_DLY  = 3,
    parameter int unsigned LS_SEC_DLY = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_i,
    input  logic       run_i,
    input  logic       lsg_hi_i,
    input  logic       sw_hi_i,
    input  logic       hsg_hi_i,
    output logic       hs_en_o,
    output logic       ls_en_o,
    output logic [2:0] state_o
);

    localparam int unsigned D_LS_OFF = at_least_one(LS_OFF_DLY);
    localparam int unsigned D_HS_ON  = at_least_one(HS_ON_DLY);
    localparam int unsigned D_HS_OFF = at_least_one(HS_OFF_DLY);
    localparam int unsigned D_LS_ON  = at_least_one(LS_ON_DLY);
    // secondary dwell is kept strictly longer than the primary one
    localparam int unsigned D_LS_SEC = (LS_SEC_DLY > D_LS_ON) ? LS_SEC_DLY : D_LS_ON + 1;
    localparam int unsigned M1 = (D_LS_OFF > D_HS_ON) ? D_LS_OFF : D_HS_ON;
    localparam int unsigned M2 = (D_HS_OFF > D_LS_SEC) ? D_HS_OFF : D_LS_SEC;
    localparam int unsigned MAX_DLY = (M1 > M2) ? M1 : M2;
    localparam int unsigned CW = $clog2(MAX_DLY + 1);

    logic [FLG_NUM-1:0] flg_raw;
    logic [FLG_NUM-1:0] flg_s;
    logic               main_run, main_clr, main_hit;
    logic               sec_run, sec_clr, sec_hit;
    logic [CW-1:0]      main_limit, sec_limit;

    assign flg_raw[FLG_LG] = lsg_hi_i;
    assign flg_raw[FLG_SW] = sw_hi_i;
    assign flg_raw[FLG_HG] = hsg_hi_i;

    dtg_flag_sync #(
        .N      (FLG_NUM),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(flg_raw),
        .sync_o (flg_s)
    );

    dtg_dwell #(.W(CW)) u_main_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (main_clr),
        .run_i  (main_run),
        .limit_i(main_limit),
        .hit_o  (main_hit)
    );

    dtg_dwell #(.W(CW)) u_sec_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (sec_clr),
        .run_i  (sec_run),
        .limit_i(sec_limit),
        .hit_o  (sec_hit)
    );

    dtg_fsm #(
        .W         (CW),
        .LS_OFF_DLY(D_LS_OFF),
        .HS_ON_DLY (D_HS_ON),
        .HS_OFF_DLY(D_HS_OFF),
        .LS_ON_DLY (D_LS_ON),
        .LS_SEC_DLY(D_LS_SEC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_i       (pwm_i),
        .run_i       (run_i),
        .lg_s_i      (flg_s[FLG_LG]),
        .sw_s_i      (flg_s[FLG_SW]),
        .hg_s_i      (flg_s[FLG_HG]),
        .main_hit_i  (main_hit),
        .sec_hit_i   (sec_hit),
        .main_run_o  (main_run),
        .main_clr_o  (main_clr),
        .main_limit_o(main_limit),
        .sec_run_o   (sec_run),
        .sec_clr_o   (sec_clr),
        .sec_limit_o (sec_limit),
        .hs_en_o     (hs_en_o),
        .ls_en_o     (ls_en_o),
        .state_o     (state_o)
    );

endmodule

// File: tb/deadtime_gate_seq_tb.sv
module deadtime_gate_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm, run, lg, sw, hg;
    logic       hs_en, ls_en;
    logic [2:0] st;

    int n_chk  = 0;
    int n_fail = 0;
    int overlap_cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    deadtime_gate_seq #(
        .LS_OFF_DLY(2), .HS_ON_DLY(5), .HS_OFF_DLY(6),
        .LS_ON_DLY(3), .LS_SEC_DLY(8), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .run_i(run),
        .lsg_hi_i(lg), .sw_hi_i(sw), .hsg_hi_i(hg),
        .hs_en_o(hs_en), .ls_en_o(ls_en), .state_o(st)
    );

    // fields: {pwm,run,lg,sw,hg} edges {hs,ls} state req
    localparam int NSTEP = 31;
    localparam logic [21:0] STEPS [NSTEP] = '{
        {5'b01100, 8'd4,  2'b00, 3'd3, 4'd7},  // R1 IDLE->WAIT_SW, R7 dwell pending
        {5'b01100, 8'd1,  2'b01, 3'd4, 4'd7},  // R7 primary dwell done
        {5'b11100, 8'd1,  2'b01, 3'd5, 4'd4},  // R4 enter LS_OFF
        {5'b11100, 8'd1,  2'b01, 3'd5, 4'd4},  // R4 still held
        {5'b11100, 8'd1,  2'b00, 3'd6, 4'd4},  // R4 drop after 2 edges
        {5'b11100, 8'd10, 2'b00, 3'd6, 4'd5},  // R5 lower gate still charged
        {5'b11000, 8'd6,  2'b00, 3'd6, 4'd5},  // R5 sync + dwell pending
        {5'b11000, 8'd1,  2'b10, 3'd1, 4'd5},  // R5 upper on
        {5'b11011, 8'd3,  2'b10, 3'd1, 4'd2},  // R2 HS_ON holds
        {5'b01011, 8'd1,  2'b10, 3'd2, 4'd6},  // R6 enter HS_OFF
        {5'b01011, 8'd5,  2'b10, 3'd2, 4'd6},  // R6 still held
        {5'b01011, 8'd1,  2'b00, 3'd3, 4'd6},  // R6 drop after 6 edges
        {5'b01011, 8'd10, 2'b00, 3'd3, 4'd7},  // R7 node high, no turn-on
        {5'b01010, 8'd9,  2'b00, 3'd3, 4'd8},  // R8 secondary dwell pending
        {5'b01010, 8'd1,  2'b01, 3'd4, 4'd8},  // R8 secondary turn-on
        {5'b11100, 8'd1,  2'b01, 3'd5, 4'd9},  // R9 enter LS_OFF
        {5'b01100, 8'd1,  2'b01, 3'd4, 4'd9},  // R9 reversal back to LS_ON
        {5'b11100, 8'd3,  2'b00, 3'd6, 4'd4},  // R4 reach WAIT_LG
        {5'b01100, 8'd1,  2'b00, 3'd3, 4'd9},  // R9 WAIT_LG -> WAIT_SW
        {5'b01100, 8'd2,  2'b00, 3'd3, 4'd7},  // R7 dwell pending
        {5'b01100, 8'd1,  2'b01, 3'd4, 4'd7},  // R7 primary beats secondary
        {5'b11000, 8'd7,  2'b00, 3'd6, 4'd5},  // R5 full rise sequence
        {5'b11000, 8'd1,  2'b10, 3'd1, 4'd5},  // R5 upper on
        {5'b01011, 8'd1,  2'b10, 3'd2, 4'd6},  // R6 enter HS_OFF
        {5'b11011, 8'd1,  2'b10, 3'd1, 4'd9},  // R9 reversal back to HS_ON
        {5'b10011, 8'd0,  2'b00, 3'd1, 4'd10}, // R10 same-cycle force low
        {5'b10011, 8'd1,  2'b00, 3'd7, 4'd10}, // R10 DISABLED
        {5'b11011, 8'd1,  2'b00, 3'd0, 4'd10}, // R10 re-enable to IDLE
        {5'b11011, 8'd1,  2'b00, 3'd6, 4'd1},  // R1 IDLE->WAIT_LG
        {5'b11011, 8'd4,  2'b00, 3'd6, 4'd5},  // R5 dwell pending
        {5'b11011, 8'd1,  2'b10, 3'd1, 4'd5}   // R5 upper on
    };

    task automatic check(input int req, input logic [4:0] act, input logic [4:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL R%0d: {hs,ls,state} actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    always @(negedge clk) if (rst_n && hs_en && ls_en) overlap_cycles++;

    initial begin
        {pwm, run, lg, sw, hg} = 5'b01100;
        repeat (3) @(negedge clk);
        check(1, {hs_en, ls_en, st}, 5'b00000);   // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NSTEP; i++) begin
            {pwm, run, lg, sw, hg} = STEPS[i][21:17];
            repeat (int'(STEPS[i][16:9])) @(posedge clk);
            #1;
            check(int'(STEPS[i][3:0]), {hs_en, ls_en, st}, STEPS[i][8:4]);
            @(negedge clk);
        end
        // directed: reset in mid-cycle returns to IDLE with both off (R1)
        rst_n = 1'b0;
        #1;
        check(1, {hs_en, ls_en, st}, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        // R3 no overlap over the whole run
        n_chk++;
        if (overlap_cycles != 0) begin
            n_fail++;
            $display("FAIL R3: overlap cycles actual=%0d expected=0", overlap_cycles);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule